// File: doc/BRIEF.md
# Reference Clock Output Gating Controller

This block decides, for each of a set of clock outputs, whether the output carries the reference clock or sits in the stopped Low/Low state, with both the true and the complement side held low. The decision takes four things into account. A global power-good input overrides everything else. A per-output enable mask, held in a small register inside the block, can force an output off. A per-output active-low enable pin starts or stops an output that the mask allows. A lock indication is needed only when the clock passes through the PLL.

A change in the decision for an output is committed only after the new value has held for a fixed number of reference cycles (1 to 3, set by a parameter). The committed state then reaches the output gate on a falling edge of the clock, so an output never starts or stops partway through a high phase. Power-down does not wait for this count: it turns every output off on the next edge. The block also drives a PLL power request, which is on only while power is good and the PLL path is selected.

Top module: `refclk_gate_ctrl`

## Requirements
- R1: When `pwr_good` is sampled low on a rising edge, every bit of `lane_run` is 0 after that edge, whatever the pins, the mask, the mode and the lock input are.
- R2: `pll_on` is a register. After each rising edge it equals `pwr_good AND NOT pll_bypass`, as sampled on that edge. It is 0 in reset.
- R3: Mask bit i (written through `en_wr` and `en_wdata`, bit i controls output i) forces output i off when it is 0, and overrides the pin.
- R4: Reset sets every mask bit to 1.
- R5: When power is good, mask bit i is 1 and the clock source is ready, output i runs when `oe_n[i]` is 0 and stops when `oe_n[i]` is 1.
- R6: When the enable condition of an output changes and then holds, `lane_run` for that output changes on exactly the LATENCY-th rising edge after the change. LATENCY is between 1 and 3.
- R7: When `pll_bypass` is 0, outputs are held off until `pll_lock` has passed through a two-flop synchroniser. After `pll_lock` rises, enabled outputs start on rising edge LATENCY+2.
- R8: When `pll_bypass` is 1, `pll_lock` has no effect, and enabled outputs run straight from the reference clock.
- R9: Each output's gate is loaded from `lane_run` on the falling edge. `clk_out_p` equals clk AND gate, and `clk_out_n` equals NOT clk AND gate, so a stopped output is low on both sides.
- R10: An enable change that holds for fewer than LATENCY cycles is never committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | High = powered, low = power-down |
| pll_bypass | input | 1 | 1 = outputs taken from the input clock, 0 = PLL path |
| pll_lock | input | 1 | PLL lock flag, asynchronous |
| oe_n | input | NUM_OUT | Active-low enable pins, one per output |
| en_wr | input | 1 | Write strobe for the enable mask |
| en_wdata | input | NUM_OUT | New mask value |
| pll_on | output | 1 | PLL power request |
| lane_run | output | NUM_OUT | Committed run state of each output |
| clk_out_p | output | NUM_OUT | Gated true clock |
| clk_out_n | output | NUM_OUT | Gated complement clock |

## Verification
The bench measures latency edge by edge after a start and after a stop. A counter that is off by one would commit one edge early or late. It also applies a stop pulse that is shorter than the latency; a design that does not clear its counter when the enable returns to its old value would drop the output. The lock is raised while the PLL path is selected, which exposes a missing or extra synchroniser stage as a start on the wrong edge. A sweep over power, mode, lock, mask and pin combinations catches a wrong priority order, such as a pin that overrides a cleared mask bit or an output that keeps running during power-down.

// File: rtl/rgc_pkg.sv
// Shared constants and helpers for the reference clock gating controller.
// Assumes the latency parameter is meant to lie between 1 and 3 cycles.
package rgc_pkg;
    localparam int LAT_MIN = 1;
    localparam int LAT_MAX = 3;
    localparam int CNT_W   = 2;

    // Clamp a requested latency into the supported window.
    function automatic int clamp_latency(input int req);
        if (req < LAT_MIN) return LAT_MIN;
        if (req > LAT_MAX) return LAT_MAX;
        return req;
    endfunction
endpackage

// File: rtl/rgc_sync.sv
// Multi-flop synchroniser that brings an asynchronous level into clk.
// Assumes the input is a slow level, so samples may be lost only by metastability.
module rgc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    // Shift the level through the chain of flops.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/rgc_mask_reg.sv
// Per-output enable mask. It resets to all ones, so every output is allowed.
// Assumes the write strobe is synchronous to clk.
module rgc_mask_reg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] mask
);
    // Hold the mask and load it when the strobe is high.
    always_ff @(posedge clk) begin
        if (!rst_n)  mask <= '1;
        else if (wr) mask <= wdata;
    end
endmodule

// File: rtl/rgc_lane.sv
// One output lane. It filters its enable request through a latency counter,
// commits the run state, and gates the clock on the falling edge so that no
// truncated pulse appears. Assumes pwr_good is synchronous to clk.
module rgc_lane #(
    parameter int LATENCY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic want,
    output logic run,
    output logic out_p,
    output logic out_n
);
    import rgc_pkg::*;
    localparam int LAT_C = clamp_latency(LATENCY);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LAT_C - 1);

    logic [CNT_W-1:0] cnt;
    logic             gate;

    // Count the cycles in which the request differs from the state, and commit at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (want == run) begin
            cnt <= '0;
        end else if (cnt == CNT_LAST) begin
            run <= want;
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Load the gate while the clock is low, so every pulse is either whole or absent.
    always_ff @(negedge clk) begin
        if (!rst_n) gate <= 1'b0;
        else        gate <= run;
    end

    assign out_p = clk & gate;
    assign out_n = ~clk & gate;
endmodule

// File: rtl/refclk_gate_ctrl.sv
// Top level of the reference clock output gating controller. It combines
// power-good, the enable mask, the active-low pins and the lock state into one
// request per lane, and drives the PLL power request.
// Assumes every input except pll_lock is synchronous to clk.
module refclk_gate_ctrl #(
    parameter int NUM_OUT     = 8,
    parameter int LATENCY     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_good,
    input  logic               pll_bypass,
    input  logic               pll_lock,
    input  logic [NUM_OUT-1:0] oe_n,
    input  logic               en_wr,
    input  logic [NUM_OUT-1:0] en_wdata,
    output logic               pll_on,
    output logic [NUM_OUT-1:0] lane_run,
    output logic [NUM_OUT-1:0] clk_out_p,
    output logic [NUM_OUT-1:0] clk_out_n
);
    logic [NUM_OUT-1:0] en_mask;
    logic               lock_ok;
    logic               src_ready;
    logic [NUM_OUT-1:0] want;

    rgc_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pll_lock), .sync_out(lock_ok)
    );

    rgc_mask_reg #(.N(NUM_OUT)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr(en_wr), .wdata(en_wdata), .mask(en_mask)
    );

    // The clock source is usable in bypass, or in PLL mode once lock is seen.
    assign src_ready = pll_bypass | lock_ok;
    // Priority: power-down, then the mask, then the active-low pin.
    assign want = (pwr_good && src_ready) ? (en_mask & ~oe_n) : '0;

    // Request PLL power only while powered and on the PLL path.
    always_ff @(posedge clk) begin
        if (!rst_n) pll_on <= 1'b0;
        else        pll_on <= pwr_good & ~pll_bypass;
    end

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
        rgc_lane #(.LATENCY(LATENCY)) u_lane (
            .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .want(want[g]),
            .run(lane_run[g]), .out_p(clk_out_p[g]), .out_n(clk_out_n[g])
        );
    end
endmodule

// File: rtl/rgc_checker.sv
// Temporal checks on the gating controller, attached by bind.
module rgc_checker #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         pwr_good,
    input logic         pll_bypass,
    input logic [N-1:0] oe_n,
    input logic [N-1:0] en_mask,
    input logic         lock_ok,
    input logic         pll_on,
    input logic [N-1:0] lane_run
);
    assert_lane_pd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (lane_run == '0));

    assert_pll_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_good || pll_bypass) |=> !pll_on);

    for (genvar i = 0; i < N; i++) begin : g_chk
        assert_start_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lane_run[i]) |-> $past(!oe_n[i] && en_mask[i] && pwr_good));

        assert_start_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lane_run[i]) |-> $past(pll_bypass || lock_ok));

        assert_stop_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(lane_run[i]) |-> $past(oe_n[i] || !en_mask[i] || !pwr_good
                                         || !(pll_bypass || lock_ok)));
    end
endmodule

bind refclk_gate_ctrl rgc_checker #(.N(NUM_OUT)) u_rgc_checker (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .pll_bypass(pll_bypass),
    .oe_n(oe_n), .en_mask(en_mask), .lock_ok(lock_ok), .pll_on(pll_on),
    .lane_run(lane_run)
);

// File: tb/refclk_gate_ctrl_test.sv
module refclk_gate_ctrl_test;
    localparam int N   = 8;
    localparam int LAT = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pwr_good = 1'b0;
    logic         pll_bypass = 1'b1;
    logic         pll_lock = 1'b0;
    logic [N-1:0] oe_n = '1;
    logic         en_wr = 1'b0;
    logic [N-1:0] en_wdata = '0;
    logic         pll_on;
    logic [N-1:0] lane_run, clk_out_p, clk_out_n;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    refclk_gate_ctrl #(.NUM_OUT(N), .LATENCY(LAT), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .pll_bypass(pll_bypass),
        .pll_lock(pll_lock), .oe_n(oe_n), .en_wr(en_wr), .en_wdata(en_wdata),
        .pll_on(pll_on), .lane_run(lane_run), .clk_out_p(clk_out_p),
        .clk_out_n(clk_out_n)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic after_edge();
        @(posedge clk);
        #2;
    endtask

    task automatic edges(input int n);
        for (int k = 0; k < n; k++) after_edge();
    endtask

    // Check the gated pair in the high phase and again in the low phase.
    task automatic check_pins(input string tag, input logic [N-1:0] exp);
        after_edge();
        check({tag, " p high"}, clk_out_p, exp);
        check({tag, " n high"}, clk_out_n, '0);
        @(negedge clk);
        #2;
        check({tag, " p low"}, clk_out_p, '0);
        check({tag, " n low"}, clk_out_n, exp);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        edges(3);
        @(negedge clk);
        rst_n = 1'b1;
        after_edge();
        check("reset lanes", lane_run, '0);
        check("R2 reset pll_on", {7'b0, pll_on}, '0);

        // R4: mask resets to ones, so opening every pin starts every lane.
        @(negedge clk);
        pwr_good = 1'b1;
        oe_n = '0;
        edges(5);
        check("R4 mask reset ones", lane_run, '1);
        check_pins("R9 running", '1);

        // R6: stop latency measured edge by edge.
        @(negedge clk);
        oe_n = '1;
        for (int e = 1; e <= 3; e++) begin
            after_edge();
            check("R6 stop latency", lane_run, (e < LAT) ? '1 : '0);
        end
        check_pins("R9 stopped low/low", '0);
        // R6: start latency.
        @(negedge clk);
        oe_n = '0;
        for (int e = 1; e <= 3; e++) begin
            after_edge();
            check("R6 start latency", lane_run, (e < LAT) ? '0 : '1);
        end

        // R10: a one-cycle stop pulse is shorter than LAT and is dropped.
        @(negedge clk);
        oe_n = 8'h0F;
        @(negedge clk);
        oe_n = '0;
        for (int e = 1; e <= 4; e++) begin
            #2;
            check("R10 short pulse ignored", lane_run, '1);
            @(negedge clk);
        end

        // R1: power-down stops every lane on the next edge.
        pwr_good = 1'b0;
        after_edge();
        check("R1 power-down lanes", lane_run, '0);
        check("R1 power-down pll", {7'b0, pll_on}, '0);
        check_pins("R1 power-down pins", '0);
        @(negedge clk);
        pwr_good = 1'b1;
        edges(LAT + 1);
        check("R1 power-up resumes", lane_run, '1);

        // R2, R7: PLL path without lock holds the lanes off.
        @(negedge clk);
        pll_bypass = 1'b0;
        after_edge();
        check("R2 pll_on in pll mode", {7'b0, pll_on}, 8'h01);
        edges(LAT + 1);
        check("R7 held without lock", lane_run, '0);
        @(negedge clk);
        pll_lock = 1'b1;
        for (int e = 1; e <= LAT + 3; e++) begin
            after_edge();
            check("R7 lock start edge", lane_run, (e < LAT + 2) ? '0 : '1);
        end

        // R8: bypass ignores a missing lock.
        @(negedge clk);
        pll_bypass = 1'b1;
        pll_lock = 1'b0;
        edges(6);
        check("R8 bypass ignores lock", lane_run, '1);
        check("R2 pll_on off in bypass", {7'b0, pll_on}, '0);

        // R3: a cleared mask bit overrides an open pin.
        @(negedge clk);
        en_wr = 1'b1;
        en_wdata = 8'h5A;
        @(negedge clk);
        en_wr = 1'b0;
        edges(LAT + 2);
        check("R3 mask override", lane_run, 8'h5A);

        // R3, R5, R1, R7, R8: sweep over power, mode, lock, mask and pins.
        for (int k = 0; k < 64; k++) begin
            logic [7:0] kk;
            logic [N-1:0] m, p, exp;
            kk = 8'(k);
            m = 8'(k * 29 + 3);
            p = 8'(k * 53) ^ 8'hC3;
            @(negedge clk);
            en_wr = 1'b1;
            en_wdata = m;
            pwr_good = kk[0] | kk[3];
            pll_bypass = kk[1];
            pll_lock = kk[2];
            oe_n = p;
            @(negedge clk);
            en_wr = 1'b0;
            edges(LAT + 4);
            exp = ((kk[0] | kk[3]) && (kk[1] || kk[2])) ? (m & ~p) : '0;
            check("R5 sweep lanes", lane_run, exp);
            check("R2 sweep pll_on", {7'b0, pll_on}, {7'b0, (kk[0] | kk[3]) & ~kk[1]});
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule